// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns characters into asynchronous serial frames on a single output line. It takes each character from a transmit queue that sits outside the block. It reads the queue's fill level and head entry, and it pulses a pop strobe when it takes a character. Each frame has a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. The line stays high between frames.

Bit timing comes from a single-cycle tick enable that runs at eight times the baud rate, so every bit holds the line for eight ticks. The frame format is sampled when a frame begins and held until it ends. Changing the settings therefore affects only later frames. When automatic flow control is on, a new frame starts only while the clear-to-send input is high. A frame already on the line always runs to its end. The block also decodes the queue level into empty and full flags, for a queue depth set by a parameter (16 by default, 32 as the larger variant).

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0 and `fifo_pop` is 0.
- R2: A frame is a 0 start bit, then the data bits with bit 0 first. Every bit lasts exactly eight `tick` pulses, and `txd` changes only on a clock edge where `tick` was high.
- R3: `cfg_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits of `fifo_data` above the selected length are not sent.
- R4: `cfg_parity` value 4 adds an odd parity bit and 6 adds an even parity bit, each computed over the sent data bits only. Value 5 adds a constant 1 and value 7 adds a constant 0. Values 0 to 3 add no parity bit.
- R5: The frame ends with one stop bit (1) when `cfg_two_stop` is 0, or two stop bits when it is 1.
- R6: A frame begins on a cycle where `tick` is high, the block is idle, `fifo_level` is nonzero and flow control allows it. In that cycle `fifo_pop` is high for one cycle and `fifo_data` is captured. A frame never begins on the tick that ends the previous one.
- R7: With `cfg_flow_en` at 1, no frame begins while `cts` is 0. With `cfg_flow_en` at 0, `cts` has no effect.
- R8: A frame already in progress completes unchanged when `cts` falls.
- R9: `busy` rises on the edge that drives the start bit. It falls on the edge that ends the last stop bit, and `txd` is 1 whenever `busy` is 0.
- R10: `fifo_empty` is 1 exactly when `fifo_level` is 0, and `fifo_full` is 1 exactly when `fifo_level` equals `FIFO_DEPTH`.
- R11: The format settings are captured at frame start. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling enable, eight pulses per bit |
| cfg_len | input | 2 | Data length code (5 + code bits) |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_parity | input | 3 | Parity mode code |
| cfg_flow_en | input | 1 | Enables clear-to-send gating of frame starts |
| cts | input | 1 | Clear to send, active high |
| fifo_level | input | $clog2(FIFO_DEPTH+1) | Entries held in the transmit queue |
| fifo_data | input | 8 | Head entry of the transmit queue |
| fifo_pop | output | 1 | Takes the head entry (one-cycle pulse) |
| txd | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress |
| fifo_empty | output | 1 | Queue level is zero |
| fifo_full | output | 1 | Queue level equals FIFO_DEPTH |

## Verification
`fifo_pop`, `fifo_empty` and `fifo_full` are combinational, so they are due in the same cycle as the inputs that cause them. `txd` and `busy` are registered and change one edge after the qualifying tick. The bench's reference model counts ticks since the frame began and looks up the expected bit as that count divided by eight. The bench drives inputs on the falling edge and compares all outputs one nanosecond after it, so every registered result is checked in the cycle after the edge that produced it.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int FIFO_DEPTH = 16,
  parameter int OSR = 8,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1),
  localparam int OSR_W = $clog2(OSR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_two_stop,
  input  logic [2:0]       cfg_parity,
  input  logic             cfg_flow_en,
  input  logic             cts,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [7:0]       fifo_data,
  output logic             fifo_pop,
  output logic             txd,
  output logic             busy,
  output logic             fifo_empty,
  output logic             fifo_full
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t              st;
  logic [OSR_W-1:0] tcnt;
  logic [7:0]       sh;
  logic [2:0]       bidx, last_idx;
  logic             par_en, par_bit, two_stop, stop_idx, txd_q;
  logic [7:0]       masked;
  logic             par_calc, go, bit_end;

  assign fifo_empty = (fifo_level == '0);
  assign fifo_full  = (fifo_level == LVL_W'(FIFO_DEPTH));
  assign go         = (st == S_IDLE) && tick && !fifo_empty && (!cfg_flow_en || cts);
  assign fifo_pop   = go;
  assign busy       = (st != S_IDLE);
  assign txd        = txd_q;
  assign bit_end    = tick && (tcnt == OSR_W'(OSR - 1));
  assign masked     = fifo_data & (8'hFF >> (2'd3 - cfg_len));

  always_comb begin
    case (cfg_parity[1:0])
      2'd0:    par_calc = ~^masked;
      2'd1:    par_calc = 1'b1;
      2'd2:    par_calc = ^masked;
      default: par_calc = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tcnt     <= '0;
      sh       <= '0;
      bidx     <= '0;
      last_idx <= '0;
      par_en   <= 1'b0;
      par_bit  <= 1'b0;
      two_stop <= 1'b0;
      stop_idx <= 1'b0;
      txd_q    <= 1'b1;
    end else if (go) begin
      st       <= S_START;
      tcnt     <= '0;
      sh       <= masked;
      last_idx <= {1'b1, cfg_len};
      par_en   <= cfg_parity[2];
      par_bit  <= par_calc;
      two_stop <= cfg_two_stop;
      txd_q    <= 1'b0;
    end else if (st != S_IDLE && tick) begin
      tcnt <= bit_end ? '0 : tcnt + 1'b1;
      if (bit_end) begin
        case (st)
          S_START: begin
            st    <= S_DATA;
            bidx  <= '0;
            txd_q <= sh[0];
            sh    <= sh >> 1;
          end
          S_DATA: begin
            if (bidx == last_idx) begin
              st       <= par_en ? S_PAR : S_STOP;
              txd_q    <= par_en ? par_bit : 1'b1;
              stop_idx <= 1'b0;
            end else begin
              bidx  <= bidx + 1'b1;
              txd_q <= sh[0];
              sh    <= sh >> 1;
            end
          end
          S_PAR: begin
            st       <= S_STOP;
            txd_q    <= 1'b1;
            stop_idx <= 1'b0;
          end
          S_STOP: begin
            if (stop_idx == two_stop) st <= S_IDLE;
            else stop_idx <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R9
  AST_POP_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> busy && !txd); // R6
  AST_POP_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !busy); // R6
  AST_TXD_ON_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(txd)); // R2
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty); // R10
  AST_BUSY_RISE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fifo_pop)); // R9

endmodule

// File: tb/uart_frame_tx_tb.sv
`timescale 1ns/1ps
module uart_frame_tx_tb_top;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, tick = 0;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_two_stop = 0, cfg_flow_en = 0, cts = 1;
  logic [2:0] cfg_parity = 3'd0;
  logic [LW-1:0] fifo_level = '0;
  logic [7:0] fifo_data = '0;
  logic fifo_pop, txd, busy, fifo_empty, fifo_full;

  uart_frame_tx #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_len(cfg_len),
    .cfg_two_stop(cfg_two_stop), .cfg_parity(cfg_parity),
    .cfg_flow_en(cfg_flow_en), .cts(cts), .fifo_level(fifo_level),
    .fifo_data(fifo_data), .fifo_pop(fifo_pop), .txd(txd), .busy(busy),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R2";
  logic [7:0] q[$];
  bit bits[$];
  bit m_busy = 0;
  int m_t = 0;
  int div = 0;

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", t, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin div <= 0; tick <= 0; end
    else begin div <= (div == 2) ? 0 : div + 1; tick <= (div == 2); end
  end

  always @(posedge clk) begin
    cyc++;
    if (fifo_pop) begin
      void'(q.pop_front());
      fifo_level <= LW'(q.size());
      fifo_data  <= q.size() != 0 ? q[0] : 8'h00;
    end
  end

  // Reference model: frame expanded into a bit list, indexed by tick count / 8
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_t = 0;
    end else if (m_busy) begin
      if (tick) begin
        m_t++;
        if (m_t == 8 * bits.size()) m_busy = 0;
      end
    end else if (tick && fifo_level != 0 && (!cfg_flow_en || cts)) begin
      int n;
      bit p;
      n = 5 + cfg_len;
      bits.delete();
      bits.push_back(1'b0);
      p = 0;
      for (int i = 0; i < n; i++) begin
        bits.push_back(fifo_data[i]);
        p = p ^ fifo_data[i];
      end
      case (cfg_parity)
        3'd4: bits.push_back(~p);
        3'd5: bits.push_back(1'b1);
        3'd6: bits.push_back(p);
        3'd7: bits.push_back(1'b0);
        default: ;
      endcase
      bits.push_back(1'b1);
      if (cfg_two_stop) bits.push_back(1'b1);
      m_busy = 1; m_t = 0;
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      bit e_txd, e_pop;
      e_txd = m_busy ? bits[m_t / 8] : 1'b1;
      e_pop = !m_busy && tick && fifo_level != 0 && (!cfg_flow_en || cts);
      chk(txd == e_txd, {tag, " txd"}, txd, e_txd);
      chk(busy == m_busy, "R9 busy", busy, m_busy);
      chk(fifo_pop == e_pop, "R6 pop", fifo_pop, e_pop);
      chk(fifo_empty == (fifo_level == 0), "R10 empty", fifo_empty, fifo_level == 0);
      chk(fifo_full == (fifo_level == DEPTH), "R10 full", fifo_full, fifo_level == DEPTH);
    end
  end

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    q.push_back(b);
    fifo_level <= LW'(q.size());
    fifo_data  <= q[0];
  endtask

  task automatic fmt(input logic [1:0] l, input logic [2:0] p, input bit two);
    @(negedge clk);
    cfg_len = l; cfg_parity = p; cfg_two_stop = two;
  endtask

  task automatic drain();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (q.size() == 0 && !m_busy && !busy && !fifo_pop) break;
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(fifo_pop == 1'b0, "R1 pop", fifo_pop, 0);
    @(negedge clk); rst_n = 1;
    repeat (10) @(negedge clk);

    tag = "R2"; fmt(2'd3, 3'd0, 0); push(8'hA5); drain();
    tag = "R3"; fmt(2'd0, 3'd0, 0); push(8'hF3); drain();
    tag = "R4"; fmt(2'd0, 3'd4, 1); push(8'h13); drain();
    tag = "R4"; fmt(2'd1, 3'd6, 0); push(8'h2D); drain();
    tag = "R4"; fmt(2'd2, 3'd5, 0); push(8'h55); drain();
    tag = "R4"; fmt(2'd3, 3'd7, 0); push(8'hFF); drain();
    tag = "R4"; fmt(2'd3, 3'd2, 0); push(8'h81); drain();
    tag = "R5"; fmt(2'd3, 3'd4, 1); push(8'h00); push(8'h7E); push(8'hC3); drain();

    tag = "R7"; cfg_flow_en = 1; cts = 0; fmt(2'd3, 3'd0, 0); push(8'h5A);
    repeat (200) @(negedge clk);
    #1; chk(busy == 1'b0, "R7 held by cts", busy, 0);
    chk(fifo_level == 1, "R7 not popped", fifo_level, 1);
    @(negedge clk); cts = 1; drain();
    cfg_flow_en = 0; cts = 0; push(8'h3C); drain(); cts = 1;

    tag = "R8"; cfg_flow_en = 1; push(8'h96);
    repeat (60) @(negedge clk);
    cts = 0; drain();
    #1; chk(busy == 1'b0, "R8 frame completed", busy, 0);
    chk(txd == 1'b1, "R8 line idle", txd, 1);
    cts = 1; cfg_flow_en = 0;

    tag = "R11"; fmt(2'd3, 3'd6, 1); push(8'hB7);
    repeat (40) @(negedge clk);
    cfg_len = 2'd0; cfg_parity = 3'd0; cfg_two_stop = 0;
    drain();

    tag = "R10"; cfg_flow_en = 1; cts = 0; fmt(2'd0, 3'd0, 0);
    for (int i = 0; i < DEPTH; i++) push(8'(i * 7 + 1));
    @(negedge clk); #1;
    chk(fifo_full == 1'b1, "R10 full at depth", fifo_full, 1);
    chk(fifo_empty == 1'b0, "R10 not empty", fifo_empty, 0);
    @(negedge clk); cts = 1; drain();
    #1; chk(fifo_empty == 1'b1, "R10 empty after drain", fifo_empty, 1);
    cfg_flow_en = 0;

    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule